// File: doc/BRIEF.md
# Programmable Raster Sync Generator

This block produces the horizontal and vertical timing for a video output raster. It runs a pixel (X) counter and a line (Y) counter, and from them it drives a visible-area flag, a horizontal sync and a vertical sync, each with its own polarity select. It also drives a single-cycle frame-start pulse that downstream logic can use to align frames. The raster is set by eight run-time writable timing values. For each axis these are the total, the visible count, the front porch and the sync width. An external controller writes them through a simple write port.

The line counter advances on the clock where the pixel counter enters horizontal sync, not when the pixel counter wraps. Because of this, a vertical sync edge always falls on the same clock as a horizontal sync leading edge. X and Y are the true on-screen coordinates while the visible flag is high. New timing values are held in a staging copy and are applied together at the frame boundary, so a frame never mixes old and new timing. Every output is registered.

Top module: `raster_sync_gen`

## Requirements
- R1: While rst_ni is low, x_o, y_o, visible_o, hsync_o, vsync_o and frame_start_o are all 0.
- R2: x_o rises by one each clock and returns to 0 after the value h_total-1, where a wrap happens when x+1 >= h_total. Every output shows the counter state of the previous clock.
- R3: y_o changes only on the clock where x_o enters the horizontal sync start value h_visible+h_front. There it rises by one, or returns to 0 when y+1 >= v_total. It does not change when x wraps.
- R4: visible_o is 1 exactly when x < h_visible and y < v_visible.
- R5: Horizontal sync is active when h_visible+h_front <= x < h_visible+h_front+h_sync, with a strict upper bound. A sync width of 0 gives no active cycles.
- R6: Vertical sync is active when v_visible+v_front <= y < v_visible+v_front+v_sync. Its active edge appears on the same clock as a horizontal sync leading edge.
- R7: hsync_pol_i and vsync_pol_i select the level of each sync: 1 gives active-high and 0 gives active-low. The selection is applied at the output register one clock after the input changes.
- R8: frame_start_o is a one-clock pulse on the output cycle where x_o = 0 and y_o = 0.
- R9: A write with cfg_we_i = 1 stores cfg_data_i into a staging copy selected by cfg_sel_i. The selector codes are: 0 h_total, 1 h_visible, 2 h_front, 3 h_sync, 4 v_total, 5 v_visible, 6 v_front, 7 v_sync. The staging copy becomes active only on the clock where x wraps while y = 0, so it takes effect from the next frame's first pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Timing write strobe |
| cfg_sel_i | input | 3 | Timing value selector |
| cfg_data_i | input | CW | Timing value to write |
| hsync_pol_i | input | 1 | 1 = active-high horizontal sync |
| vsync_pol_i | input | 1 | 1 = active-high vertical sync |
| x_o | output | CW | Pixel coordinate |
| y_o | output | CW | Line coordinate |
| visible_o | output | 1 | Inside the visible area |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| frame_start_o | output | 1 | One-clock pulse at the first pixel of a frame |

## Verification
Two events can fall on the same clock: the line counter step that starts vertical sync, and the leading edge of horizontal sync. The bench runs whole frames with a sync width of one line and records each rising edge of vsync_o. It then requires that hsync_o rose on that same sampled cycle. A second collision, a write to the staging copy near the frame boundary, is judged against a cycle-exact model that applies the staged values only at the wrap with y = 0. The model also compares the largest x_o seen before and after the boundary.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int NUM_REGS    = 8;
  localparam int SEL_W       = 3;
  localparam int AXIS_STRIDE = 4;

  // Per-axis offsets within the timing array; axis base = axis * AXIS_STRIDE
  typedef enum logic [SEL_W-1:0] {
    OFS_TOTAL = 3'd0,
    OFS_VIS   = 3'd1,
    OFS_FRONT = 3'd2,
    OFS_SYNC  = 3'd3
  } axis_ofs_e;
endpackage

// File: rtl/raster_cfg_regs.sv
module raster_cfg_regs import raster_pkg::*; #(
  parameter int CW = 12,
  parameter logic [NUM_REGS-1:0][CW-1:0] DEFAULTS = '0
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [SEL_W-1:0]             sel_i,
  input  logic [CW-1:0]                data_i,
  input  logic                         commit_i,
  output logic [NUM_REGS-1:0][CW-1:0]  active_o
);
  logic [NUM_REGS-1:0][CW-1:0] shadow_q;
  logic [NUM_REGS-1:0][CW-1:0] active_q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q[g] <= DEFAULTS[g];
      end else if (we_i && (sel_i == SEL_W'(g))) begin
        shadow_q[g] <= data_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        active_q[g] <= DEFAULTS[g];
      end else if (commit_i) begin
        active_q[g] <= shadow_q[g];
      end
    end
  end

  assign active_o = active_q;

  // R9: live timing only moves at a frame boundary
  assert_hold_between_frames_R9: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    !$past(commit_i) |-> $stable(active_q));
endmodule

// File: rtl/raster_axis_counter.sv
module raster_axis_counter #(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic [CW-1:0] total_i,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;
  logic [CW:0]   inc_w;

  assign inc_w  = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
  // >= keeps the counter bounded when a smaller total is committed
  assign last_o = inc_w >= {1'b0, total_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= last_o ? '0 : inc_w[CW-1:0];
    end
  end

  assign cnt_o = cnt_q;

  assert_step_or_wrap_R2: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt_q) |-> (cnt_q == '0 || cnt_q == $past(cnt_q) + 1'b1));

  assert_hold_without_step_R2: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    !$past(step_i) |-> $stable(cnt_q));
endmodule

// File: rtl/raster_window.sv
module raster_window #(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] vis_i,
  input  logic [CW-1:0] front_i,
  input  logic [CW-1:0] sync_i,
  output logic          in_vis_o,
  output logic          sync_act_o,
  output logic [CW:0]   start_o
);
  logic [CW:0]   start_w;
  logic [CW+1:0] stop_w;

  assign start_w    = {1'b0, vis_i} + {1'b0, front_i};
  assign stop_w     = {1'b0, start_w} + {2'b00, sync_i};
  assign in_vis_o   = cnt_i < vis_i;
  assign sync_act_o = ({2'b00, cnt_i} >= {1'b0, start_w}) && ({2'b00, cnt_i} < stop_w);
  assign start_o    = start_w;

  // R5/R6: a sync window never overlaps the visible span
  assert_sync_outside_visible_R5: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    sync_act_o |-> !in_vis_o);
endmodule

// File: rtl/raster_out_stage.sv
module raster_out_stage #(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] x_i,
  input  logic [CW-1:0] y_i,
  input  logic          vis_i,
  input  logic          h_act_i,
  input  logic          v_act_i,
  input  logic          h_pol_i,
  input  logic          v_pol_i,
  input  logic          fs_i,
  output logic [CW-1:0] x_o,
  output logic [CW-1:0] y_o,
  output logic          visible_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          frame_start_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_o           <= '0;
      y_o           <= '0;
      visible_o     <= 1'b0;
      hsync_o       <= 1'b0;
      vsync_o       <= 1'b0;
      frame_start_o <= 1'b0;
    end else begin
      x_o           <= x_i;
      y_o           <= y_i;
      visible_o     <= vis_i;
      hsync_o       <= h_act_i ~^ h_pol_i;
      vsync_o       <= v_act_i ~^ v_pol_i;
      frame_start_o <= fs_i;
    end
  end

  assert_frame_start_origin_R8: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (x_o == '0 && y_o == '0));

  assert_hsync_idle_in_visible_R7: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    visible_o |-> (hsync_o != $past(h_pol_i)));
endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen import raster_pkg::*; #(
  parameter int CW          = 12,
  parameter int H_TOTAL_DEF = 800,
  parameter int H_VIS_DEF   = 576,
  parameter int H_FRONT_DEF = 136,
  parameter int H_SYNC_DEF  = 64,
  parameter int V_TOTAL_DEF = 417,
  parameter int V_VIS_DEF   = 378,
  parameter int V_FRONT_DEF = 25,
  parameter int V_SYNC_DEF  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [SEL_W-1:0] cfg_sel_i,
  input  logic [CW-1:0]    cfg_data_i,
  input  logic             hsync_pol_i,
  input  logic             vsync_pol_i,
  output logic [CW-1:0]    x_o,
  output logic [CW-1:0]    y_o,
  output logic             visible_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             frame_start_o
);
  localparam int NUM_AXES = NUM_REGS / AXIS_STRIDE;
  localparam logic [NUM_REGS-1:0][CW-1:0] DEFAULTS = {
    CW'(V_SYNC_DEF), CW'(V_FRONT_DEF), CW'(V_VIS_DEF), CW'(V_TOTAL_DEF),
    CW'(H_SYNC_DEF), CW'(H_FRONT_DEF), CW'(H_VIS_DEF), CW'(H_TOTAL_DEF)
  };

  logic [NUM_REGS-1:0][CW-1:0] timing;
  logic [NUM_AXES-1:0][CW-1:0] cnt;
  logic [NUM_AXES-1:0][CW:0]   start;
  logic [NUM_AXES-1:0]         last, in_vis, sync_act, step;
  logic [CW-1:0]               h_nxt;
  logic                        h_enter, commit, fs;

  raster_cfg_regs #(.CW(CW), .DEFAULTS(DEFAULTS)) i_cfg (
    .clk_i, .rst_ni,
    .we_i     (cfg_we_i),
    .sel_i    (cfg_sel_i),
    .data_i   (cfg_data_i),
    .commit_i (commit),
    .active_o (timing)
  );

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
    localparam int BASE = a * AXIS_STRIDE;

    raster_axis_counter #(.CW(CW)) i_cnt (
      .clk_i, .rst_ni,
      .step_i  (step[a]),
      .total_i (timing[BASE + OFS_TOTAL]),
      .cnt_o   (cnt[a]),
      .last_o  (last[a])
    );

    raster_window #(.CW(CW)) i_win (
      .clk_i, .rst_ni,
      .cnt_i      (cnt[a]),
      .vis_i      (timing[BASE + OFS_VIS]),
      .front_i    (timing[BASE + OFS_FRONT]),
      .sync_i     (timing[BASE + OFS_SYNC]),
      .in_vis_o   (in_vis[a]),
      .sync_act_o (sync_act[a]),
      .start_o    (start[a])
    );
  end

  // Line counter steps as X moves onto the sync start, so Y and HSYNC change together
  assign h_nxt   = last[0] ? '0 : cnt[0] + 1'b1;
  assign h_enter = ({1'b0, h_nxt} == start[0]);
  assign step    = {h_enter, 1'b1};
  assign commit  = last[0] && (cnt[1] == '0);
  assign fs      = (cnt[0] == '0) && (cnt[1] == '0);

  raster_out_stage #(.CW(CW)) i_out (
    .clk_i, .rst_ni,
    .x_i           (cnt[0]),
    .y_i           (cnt[1]),
    .vis_i         (in_vis[0] && in_vis[1]),
    .h_act_i       (sync_act[0]),
    .v_act_i       (sync_act[1]),
    .h_pol_i       (hsync_pol_i),
    .v_pol_i       (vsync_pol_i),
    .fs_i          (fs),
    .x_o, .y_o, .visible_o, .hsync_o, .vsync_o, .frame_start_o
  );

  assert_v_step_at_hsync_R3: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt[1]) |-> $past(h_enter));

  assert_y_wrap_R3: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (h_enter && last[1]) |=> (cnt[1] == '0));

  assert_vsync_on_hsync_edge_R6: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    ($rose(sync_act[1]) && !$past(commit)) |-> ({1'b0, cnt[0]} == start[0]));

  assert_vsync_from_start_line_R6: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    ($rose(sync_act[1]) && !$past(commit)) |-> ({1'b0, cnt[1]} == start[1]));
endmodule

// File: tb/test_raster_sync_gen.sv
module test_raster_sync_gen;
  localparam int CLK_PERIOD = 10;
  localparam int CW         = 12;
  localparam int WATCHDOG   = 200000;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [CW-1:0] cfg_data = '0;
  logic          hsync_pol = 1'b1;
  logic          vsync_pol = 1'b1;
  logic [CW-1:0] x_o, y_o;
  logic          visible_o, hsync_o, vsync_o, frame_start_o;

  raster_sync_gen #(
    .CW(CW),
    .H_TOTAL_DEF(16), .H_VIS_DEF(8), .H_FRONT_DEF(3), .H_SYNC_DEF(2),
    .V_TOTAL_DEF(10), .V_VIS_DEF(5), .V_FRONT_DEF(2), .V_SYNC_DEF(1)
  ) i_raster_sync_gen (
    .clk_i(clk), .rst_ni,
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data),
    .hsync_pol_i(hsync_pol), .vsync_pol_i(vsync_pol),
    .x_o, .y_o, .visible_o, .hsync_o, .vsync_o, .frame_start_o
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int mx = 0, my = 0;
  int act[8] = '{16, 8, 3, 2, 10, 5, 2, 1};
  int shd[8] = '{16, 8, 3, 2, 10, 5, 2, 1};

  task automatic check(input bit ok, input string what, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, actual, expected);
    end
  endtask

  function automatic bit in_win(input int c, input int v, input int f, input int s);
    return (c >= v + f) && (c < v + f + s);
  endfunction

  // One clock: predict outputs from model state, advance the model, compare at negedge
  task automatic step();
    int ex, ey, nx;
    bit ev, eh, evs, efs, commit;
    @(posedge clk);
    ex  = mx; ey = my;
    ev  = (mx < act[1]) && (my < act[5]);
    eh  = in_win(mx, act[1], act[2], act[3]) ~^ hsync_pol;
    evs = in_win(my, act[5], act[6], act[7]) ~^ vsync_pol;
    efs = (mx == 0) && (my == 0);
    commit = (mx + 1 >= act[0]) && (my == 0);
    nx = (mx + 1 >= act[0]) ? 0 : mx + 1;
    if (nx == act[1] + act[2]) my = (my + 1 >= act[4]) ? 0 : my + 1;
    mx = nx;
    if (commit) for (int i = 0; i < 8; i++) act[i] = shd[i];
    if (cfg_we) shd[cfg_sel] = int'(cfg_data);
    @(negedge clk);
    check(int'(x_o) == ex, "R2 x_o", int'(x_o), ex);
    check(int'(y_o) == ey, "R3 y_o", int'(y_o), ey);
    check(visible_o == ev, "R4 visible_o", visible_o, ev);
    check(hsync_o == eh, "R5/R7 hsync_o", hsync_o, eh);
    check(vsync_o == evs, "R6/R7 vsync_o", vsync_o, evs);
    check(frame_start_o == efs, "R8 frame_start_o", frame_start_o, efs);
  endtask

  task automatic cfg_write(input int sel, input int data);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_data = CW'(data);
    step();
    cfg_we = 1'b0;
  endtask

  task automatic wait_frame(input string tag);
    int n = 0;
    while (!frame_start_o && n < 400) begin step(); n++; end
    check(frame_start_o, tag, frame_start_o, 1);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(x_o == '0 && y_o == '0, "R1 counters in reset", int'(x_o) + int'(y_o), 0);
    check(!visible_o && !hsync_o && !vsync_o && !frame_start_o, "R1 flags in reset",
          int'({visible_o, hsync_o, vsync_o, frame_start_o}), 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_frames();
    int fs_cnt = 0, max_x = 0;
    for (int i = 0; i < 320; i++) begin
      step();
      if (frame_start_o) fs_cnt++;
      if (int'(x_o) > max_x) max_x = int'(x_o);
    end
    check(fs_cnt == 2, "R8 frame starts in two frames", fs_cnt, 2);
    check(max_x == 15, "R2 largest x", max_x, 15);
  endtask

  task automatic t_sync_align();
    bit prev_h = hsync_o, prev_v = vsync_o;
    int rises = 0;
    for (int i = 0; i < 160; i++) begin
      step();
      if (vsync_o && !prev_v) begin
        rises++;
        check(hsync_o && !prev_h, "R6 vsync edge with hsync edge", hsync_o, 1);
        check(int'(y_o) == 7, "R3 y at vsync start", int'(y_o), 7);
      end
      prev_h = hsync_o; prev_v = vsync_o;
    end
    check(rises == 1, "R6 one vsync per frame", rises, 1);
  endtask

  task automatic t_polarity();
    int h_low = 0, v_low = 0;
    wait_frame("R8 frame before polarity test");
    hsync_pol = 1'b0; vsync_pol = 1'b0;
    for (int i = 0; i < 160; i++) begin
      step();
      if (!hsync_o) h_low++;
      if (!vsync_o) v_low++;
    end
    check(h_low == 20, "R7 active-low hsync cycles", h_low, 20);
    check(v_low == 16, "R7 active-low vsync cycles", v_low, 16);
    hsync_pol = 1'b1; vsync_pol = 1'b1;
    step();
  endtask

  task automatic t_reprogram();
    int max_x = 0, max_y = 0;
    wait_frame("R8 frame before reprogram");
    repeat (20) step();
    cfg_write(0, 20); cfg_write(1, 10); cfg_write(2, 4); cfg_write(3, 3);
    cfg_write(4, 8);  cfg_write(5, 4);  cfg_write(6, 1); cfg_write(7, 2);
    while (!frame_start_o) begin
      step();
      if (int'(x_o) > max_x) max_x = int'(x_o);
    end
    check(max_x == 15, "R9 old total kept until frame start", max_x, 15);
    max_x = 0;
    for (int i = 0; i < 160; i++) begin
      if (int'(x_o) > max_x) max_x = int'(x_o);
      if (int'(y_o) > max_y) max_y = int'(y_o);
      step();
    end
    check(max_x == 19, "R9 new h_total applied", max_x, 19);
    check(max_y == 7, "R9 new v_total applied", max_y, 7);
    check(frame_start_o, "R8 next frame start after 160 cycles", frame_start_o, 1);
  endtask

  task automatic t_zero_sync();
    int h_act = 0;
    cfg_write(3, 0);
    wait_frame("R8 frame before zero-width sync");
    for (int i = 0; i < 160; i++) begin
      step();
      if (hsync_o) h_act++;
    end
    check(h_act == 0, "R5 zero sync width never active", h_act, 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_frames();
    t_sync_align();
    t_polarity();
    t_reprogram();
    t_zero_sync();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule